// File: doc/BRIEF.md
# Converter Run/Stop Supervisor with Soft-Start

This block decides whether a half-bridge converter may switch. Each clock it reads three digitized measurements: the controller supply, the divided input-line voltage and the die temperature code. Each measurement goes through its own two-level (hysteretic) comparator. The threshold levels come in on ports. The comparator flags drive a four-state machine: SHUTDOWN, LOCKOUT, SOFTSTART and RUN.

While the converter is stopped, a digital soft-start ramp is held at zero. Once every condition is healthy, the ramp climbs by a programmable step per clock until it reaches a clamp level. The drive sequencer may switch only after the ramp has passed a gate level, so the start of the ramp is a dead zone with no switching. A separate high-side inhibit stops only the high-side primary switch while the line-detect code comes within a margin of the supply code.

State transitions:
- SHUTDOWN is entered from any state while the line-detect shutdown flag is low. This has the highest priority.
- LOCKOUT is entered from any state while the supply is under its lockout level, the line is under its undervoltage level, or the die is over temperature.
- SHUTDOWN or LOCKOUT goes to SOFTSTART once all flags are healthy.
- SOFTSTART goes to RUN when the ramp equals the clamp.
- RUN stays in RUN until a fault occurs.

Top module: `pfs_supervisor`

## Requirements
- R1: During and directly after reset the state is SHUTDOWN (code 0), the ramp is 0, drive_en is 0 and hs_inhibit is 1. The state codes are SHUTDOWN=0, LOCKOUT=1, SOFTSTART=2, RUN=3.
- R2: The supply-good flag sets when vcc_code >= uvlo_on_lvl and clears when vcc_code < uvlo_off_lvl. Between the two levels it holds. While it is clear, the state is LOCKOUT unless R3 applies.
- R3: The shutdown-release flag sets when vdet_code >= sd_on_lvl and clears when vdet_code < sd_off_lvl. Between the two levels it holds. While it is clear, the state is SHUTDOWN.
- R4: The line-good flag sets when vdet_code >= uv_on_lvl and clears when vdet_code < uv_off_lvl. Between the two levels it holds. While it is clear, the state is LOCKOUT unless R3 applies.
- R5: The over-temperature flag sets when temp_code >= ot_trip_lvl and clears when temp_code < ot_clear_lvl. It is set out of reset. While it is set, the state is LOCKOUT unless R3 applies.
- R6: In SOFTSTART and RUN, the ramp increases by ss_step every clock and saturates at ss_clamp_lvl.
- R7: drive_en is 1 in RUN, and in SOFTSTART only while the ramp is >= ss_gate_lvl. It is 0 otherwise.
- R8: SOFTSTART goes to RUN on the clock after the ramp equals ss_clamp_lvl. In RUN the ramp equals the clamp.
- R9: After SHUTDOWN or LOCKOUT the ramp is 0. Leaving a fault restarts SOFTSTART from a ramp of 0.
- R10: hs_inhibit is 1 while vdet_code + hs_margin > vcc_code and 0 otherwise. It is registered, so it follows one clock later, and it does not change the state or drive_en.
- R11: A flag change reaches the state output two clocks after the input change. SHUTDOWN takes priority over LOCKOUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_code | input | VW | Digitized controller supply |
| vdet_code | input | VW | Digitized line-detect divider voltage |
| temp_code | input | TW | Die temperature code |
| uvlo_on_lvl | input | VW | Supply lockout release level |
| uvlo_off_lvl | input | VW | Supply lockout entry level |
| sd_on_lvl | input | VW | Shutdown release level |
| sd_off_lvl | input | VW | Shutdown entry level |
| uv_on_lvl | input | VW | Line undervoltage release level |
| uv_off_lvl | input | VW | Line undervoltage entry level |
| ot_trip_lvl | input | TW | Over-temperature trip level |
| ot_clear_lvl | input | TW | Over-temperature clear level |
| hs_margin | input | VW | Margin below the supply for the high-side inhibit |
| ss_step | input | SW | Ramp increment per clock |
| ss_gate_lvl | input | RW | Ramp level at which switching begins |
| ss_clamp_lvl | input | RW | Ramp clamp level |
| state | output | 2 | Supervisor state code |
| ss_ramp | output | RW | Soft-start ramp code |
| drive_en | output | 1 | Enable to the drive sequencer |
| hs_inhibit | output | 1 | Stop the high-side primary switch |

## Verification
A stuck or mis-latched comparator flag shows up at the state output two clocks after the input crosses a level. A wrong hold inside a hysteresis band shows up as the state changing while the input sits between its two levels. A ramp that fails to clear or saturate appears on ss_ramp one clock after the state leaves or enters SOFTSTART, and drive_en betrays a wrong dead-zone boundary in the same cycle the ramp crosses the gate level. The bench keeps a cycle-level model of the requirements and compares all four outputs every clock under random supply, line and temperature sequences. It also runs directed crossings of each band edge.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    typedef enum logic [1:0] {
        ST_SHDN = 2'd0,
        ST_LOCK = 2'd1,
        ST_SOFT = 2'd2,
        ST_RUN  = 2'd3
    } pfs_state_e;
endpackage

// File: rtl/pfs_hyst_cmp.sv
module pfs_hyst_cmp #(
    parameter int W       = 12,
    parameter bit RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] set_lvl,
    input  logic [W-1:0] clr_lvl,
    output logic         flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                flag <= RST_VAL;
        else if (level >= set_lvl) flag <= 1'b1;
        else if (level < clr_lvl)  flag <= 1'b0;
    end

    // R2 R3 R4 R5: the flag rises only after the input reached the set level
    assert_hyst_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(level) >= $past(set_lvl)));
    // R2 R3 R4 R5: the flag falls only after the input went under the clear level
    assert_hyst_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> ($past(level) < $past(clr_lvl)));
endmodule

// File: rtl/pfs_ramp.sv
module pfs_ramp #(
    parameter int RW = 12,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [SW-1:0] step,
    input  logic [RW-1:0] clamp_lvl,
    output logic [RW-1:0] ramp
);
    logic [RW:0] sum;
    assign sum = {1'b0, ramp} + {{(RW + 1 - SW){1'b0}}, step};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       ramp <= '0;
        else if (!active)                 ramp <= '0;
        else if (sum >= {1'b0, clamp_lvl}) ramp <= clamp_lvl;
        else                              ramp <= sum[RW-1:0];
    end

    // R6: while the ramp keeps running it never steps downward
    assert_ramp_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && $stable(clamp_lvl)) |-> (ramp >= $past(ramp)));
endmodule

// File: rtl/pfs_hs_guard.sv
module pfs_hs_guard #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vdet,
    input  logic [W-1:0] vcc,
    input  logic [W-1:0] margin,
    output logic         inhibit
);
    logic [W:0] near;
    assign near = {1'b0, vdet} + {1'b0, margin};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inhibit <= 1'b1;
        else        inhibit <= (near > {1'b0, vcc});
    end
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
    import pfs_pkg::*;
#(
    parameter int VW = 12,
    parameter int TW = 8,
    parameter int RW = 12,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vcc_code,
    input  logic [VW-1:0] vdet_code,
    input  logic [TW-1:0] temp_code,
    input  logic [VW-1:0] uvlo_on_lvl,
    input  logic [VW-1:0] uvlo_off_lvl,
    input  logic [VW-1:0] sd_on_lvl,
    input  logic [VW-1:0] sd_off_lvl,
    input  logic [VW-1:0] uv_on_lvl,
    input  logic [VW-1:0] uv_off_lvl,
    input  logic [TW-1:0] ot_trip_lvl,
    input  logic [TW-1:0] ot_clear_lvl,
    input  logic [VW-1:0] hs_margin,
    input  logic [SW-1:0] ss_step,
    input  logic [RW-1:0] ss_gate_lvl,
    input  logic [RW-1:0] ss_clamp_lvl,
    output logic [1:0]    state,
    output logic [RW-1:0] ss_ramp,
    output logic          drive_en,
    output logic          hs_inhibit
);
    logic vcc_ok, sd_ok, line_ok, hot;
    pfs_state_e st_q, st_d;
    logic ramp_active;

    pfs_hyst_cmp #(.W(VW), .RST_VAL(1'b0)) u_uvlo (
        .clk(clk), .rst_n(rst_n), .level(vcc_code),
        .set_lvl(uvlo_on_lvl), .clr_lvl(uvlo_off_lvl), .flag(vcc_ok));

    pfs_hyst_cmp #(.W(VW), .RST_VAL(1'b0)) u_shdn (
        .clk(clk), .rst_n(rst_n), .level(vdet_code),
        .set_lvl(sd_on_lvl), .clr_lvl(sd_off_lvl), .flag(sd_ok));

    pfs_hyst_cmp #(.W(VW), .RST_VAL(1'b0)) u_line (
        .clk(clk), .rst_n(rst_n), .level(vdet_code),
        .set_lvl(uv_on_lvl), .clr_lvl(uv_off_lvl), .flag(line_ok));

    pfs_hyst_cmp #(.W(TW), .RST_VAL(1'b1)) u_temp (
        .clk(clk), .rst_n(rst_n), .level(temp_code),
        .set_lvl(ot_trip_lvl), .clr_lvl(ot_clear_lvl), .flag(hot));

    pfs_hs_guard #(.W(VW)) u_hs (
        .clk(clk), .rst_n(rst_n), .vdet(vdet_code), .vcc(vcc_code),
        .margin(hs_margin), .inhibit(hs_inhibit));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_SHDN;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!sd_ok) begin
            st_d = ST_SHDN;
        end else if (!vcc_ok || !line_ok || hot) begin
            st_d = ST_LOCK;
        end else begin
            unique case (st_q)
                ST_SHDN, ST_LOCK: st_d = ST_SOFT;
                ST_SOFT:          st_d = (ss_ramp == ss_clamp_lvl) ? ST_RUN : ST_SOFT;
                ST_RUN:           st_d = ST_RUN;
                default:          st_d = ST_SHDN;
            endcase
        end
    end

    // outputs
    always_comb begin
        ramp_active = 1'b0;
        drive_en    = 1'b0;
        unique case (st_q)
            ST_SHDN, ST_LOCK: begin
                ramp_active = 1'b0;
                drive_en    = 1'b0;
            end
            ST_SOFT: begin
                ramp_active = 1'b1;
                drive_en    = (ss_ramp >= ss_gate_lvl);
            end
            ST_RUN: begin
                ramp_active = 1'b1;
                drive_en    = 1'b1;
            end
            default: begin
                ramp_active = 1'b0;
                drive_en    = 1'b0;
            end
        endcase
    end

    assign state = st_q;

    pfs_ramp #(.RW(RW), .SW(SW)) u_ramp (
        .clk(clk), .rst_n(rst_n), .active(ramp_active), .step(ss_step),
        .clamp_lvl(ss_clamp_lvl), .ramp(ss_ramp));

    // R3: a cleared shutdown flag forces SHUTDOWN on the next clock
    assert_shdn_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_ok |=> (st_q == ST_SHDN));
    // R8: the ramp sits at the clamp throughout RUN
    assert_run_at_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && $stable(ss_clamp_lvl)) |-> (ss_ramp == ss_clamp_lvl));
    // R9: a stopped state leaves the ramp at zero
    assert_stop_clears_ramp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHDN || st_q == ST_LOCK) |=> (ss_ramp == '0));
    // R7: switching never comes out of a stopped state
    assert_no_drive_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHDN || st_q == ST_LOCK) |-> !drive_en);
endmodule

// File: tb/tb_pfs_supervisor.sv
module tb_pfs_supervisor;
    localparam int VW = 12, TW = 8, RW = 12, SW = 8;
    localparam int UVLO_ON = 880, UVLO_OFF = 830;
    localparam int SD_ON = 55, SD_OFF = 35;
    localparam int UV_ON = 330, UV_OFF = 300;
    localparam int OT_TRIP = 160, OT_CLR = 130;
    localparam int MARGIN = 30, GATE = 120, CLAMP = 800;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [VW-1:0] vcc_code = '0, vdet_code = '0;
    logic [TW-1:0] temp_code = 8'd25;
    logic [SW-1:0] ss_step = 8'd100;
    logic [1:0] state;
    logic [RW-1:0] ss_ramp;
    logic drive_en, hs_inhibit;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pfs_supervisor #(.VW(VW), .TW(TW), .RW(RW), .SW(SW)) dut (
        .clk(clk), .rst_n(rst_n), .vcc_code(vcc_code), .vdet_code(vdet_code),
        .temp_code(temp_code),
        .uvlo_on_lvl(12'(UVLO_ON)), .uvlo_off_lvl(12'(UVLO_OFF)),
        .sd_on_lvl(12'(SD_ON)), .sd_off_lvl(12'(SD_OFF)),
        .uv_on_lvl(12'(UV_ON)), .uv_off_lvl(12'(UV_OFF)),
        .ot_trip_lvl(8'(OT_TRIP)), .ot_clear_lvl(8'(OT_CLR)),
        .hs_margin(12'(MARGIN)), .ss_step(ss_step),
        .ss_gate_lvl(12'(GATE)), .ss_clamp_lvl(12'(CLAMP)),
        .state(state), .ss_ramp(ss_ramp), .drive_en(drive_en), .hs_inhibit(hs_inhibit));

    // reference model built from the requirements
    bit m_vok, m_sdok, m_lok, m_hot, m_inh;
    int m_st, m_ramp;

    function automatic bit f_hyst(int lvl, int on, int off, bit prev);
        if (lvl >= on) return 1'b1;
        if (lvl < off) return 1'b0;
        return prev;
    endfunction

    function automatic int f_next(bit sdok, bit vok, bit lok, bit hot, int st, int rmp);
        if (!sdok) return 0;
        if (!vok || !lok || hot) return 1;
        if (st == 0 || st == 1) return 2;
        if (st == 2) return (rmp == CLAMP) ? 3 : 2;
        return 3;
    endfunction

    function automatic int f_ramp(int st, int rmp, int step);
        if (st < 2) return 0;
        return (rmp + step >= CLAMP) ? CLAMP : rmp + step;
    endfunction

    function automatic bit f_drive(int st, int rmp);
        return (st == 3) || (st == 2 && rmp >= GATE);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_vok <= 0; m_sdok <= 0; m_lok <= 0; m_hot <= 1; m_inh <= 1;
            m_st <= 0; m_ramp <= 0;
        end else begin
            m_vok  <= f_hyst(int'(vcc_code), UVLO_ON, UVLO_OFF, m_vok);
            m_sdok <= f_hyst(int'(vdet_code), SD_ON, SD_OFF, m_sdok);
            m_lok  <= f_hyst(int'(vdet_code), UV_ON, UV_OFF, m_lok);
            m_hot  <= f_hyst(int'(temp_code), OT_TRIP, OT_CLR, m_hot);
            m_inh  <= (int'(vdet_code) + MARGIN > int'(vcc_code));
            m_st   <= f_next(m_sdok, m_vok, m_lok, m_hot, m_st, m_ramp);
            m_ramp <= f_ramp(m_st, m_ramp, int'(ss_step));
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R11 state", int'(state), m_st);
            chk("R6 ramp", int'(ss_ramp), m_ramp);
            chk("R7 drive_en", int'(drive_en), int'(f_drive(m_st, m_ramp)));
            chk("R10 hs_inhibit", int'(hs_inhibit), int'(m_inh));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        tick(4);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 state", int'(state), 0);
        chk("R1 ramp", int'(ss_ramp), 0);
        chk("R1 drive_en", int'(drive_en), 0);
        chk("R1 hs_inhibit", int'(hs_inhibit), 1);

        vcc_code = 12'd1200; vdet_code = 12'd480; temp_code = 8'd25; ss_step = 8'd100;
        tick(3);
        chk("R11 two-clock entry to SOFTSTART", int'(state), 2);
        chk("R7 dead zone ramp", int'(ss_ramp), 100);
        chk("R7 dead zone drive", int'(drive_en), 0);
        tick(1);
        chk("R7 past gate drive", int'(drive_en), 1);
        tick(8);
        chk("R8 RUN reached", int'(state), 3);
        chk("R8 ramp at clamp", int'(ss_ramp), CLAMP);

        vcc_code = 12'd850; tick(3);
        chk("R2 band holds RUN", int'(state), 3);
        vcc_code = 12'd820; tick(3);
        chk("R2 lockout entry", int'(state), 1);
        chk("R9 ramp cleared", int'(ss_ramp), 0);
        vcc_code = 12'd850; tick(5);
        chk("R2 band holds LOCKOUT", int'(state), 1);
        vcc_code = 12'd1200; tick(3);
        chk("R9 restart state", int'(state), 2);
        chk("R9 restart from zero", int'(ss_ramp), 100);
        tick(15);

        temp_code = 8'd170; tick(3);
        chk("R5 over-temperature", int'(state), 1);
        temp_code = 8'd140; tick(5);
        chk("R5 temperature band holds", int'(state), 1);
        temp_code = 8'd120; tick(3);
        chk("R5 temperature cleared", int'(state), 2);
        tick(15);

        vdet_code = 12'd310; tick(4);
        chk("R4 line band holds RUN", int'(state), 3);
        vdet_code = 12'd290; tick(3);
        chk("R4 line undervoltage", int'(state), 1);
        vdet_code = 12'd30; temp_code = 8'd170; tick(3);
        chk("R3 shutdown over lockout", int'(state), 0);
        vdet_code = 12'd50; tick(5);
        chk("R3 shutdown band holds", int'(state), 0);
        vdet_code = 12'd480; temp_code = 8'd25; tick(20);
        chk("R8 RUN after recovery", int'(state), 3);

        vdet_code = 12'd1171; tick(1);
        chk("R10 inhibit set", int'(hs_inhibit), 1);
        tick(2);
        chk("R10 RUN unaffected", int'(state), 3);
        chk("R10 drive unaffected", int'(drive_en), 1);
        vdet_code = 12'd1170; tick(1);
        chk("R10 inhibit released", int'(hs_inhibit), 0);

        // constrained random segments
        for (int seg = 0; seg < 300; seg++) begin
            int pick;
            pick = int'($urandom_range(9, 0));
            ss_step   = 8'($urandom_range(255, 1));
            vcc_code  = 12'($urandom_range(1300, 880));
            vdet_code = 12'($urandom_range(700, 330));
            temp_code = 8'($urandom_range(159, 20));
            if (pick == 6) vcc_code  = 12'($urandom_range(900, 700));
            if (pick == 7) vdet_code = 12'($urandom_range(60, 0));
            if (pick == 8) vdet_code = 12'($urandom_range(340, 280));
            if (pick == 9) temp_code = 8'($urandom_range(175, 125));
            if (pick == 5) vdet_code = vcc_code - 12'($urandom_range(40, 20));
            tick(int'($urandom_range(80, 20)));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule